// File: doc/BRIEF.md
# Configurable Macrocell Storage and Control Selector

This block is the storage bit of one programmable-logic cell, plus the selection logic around it. It takes the cell's combinational XOR result and a fast pin path as data. It also takes a set of global clocks, a global clear and global output enables, and three control product terms that the steering logic has set aside (called PT3, PT4 and PT5 here). Static configuration inputs pick the following:

- the storage kind: D flip-flop, toggle flip-flop or transparent latch;
- the clock source and an optional clock enable;
- the asynchronous clear and preset sources;
- the data source;
- the feedback source;
- the output source;
- the pad output-enable source.

The design is written for an FPGA, so everything runs on one system clock `clk`. The global clocks and PT4 are treated as ordinary signals. A storage "clock edge" is a low-to-high change of the chosen clock level, detected on a `clk` rising edge. The asynchronous clear and preset are level-sensitive and are applied on the next `clk` edge. The synchronous reset `rst` stands for power-up.

Top module: `mc_cell`

## Requirements
- R1: While `rst` is high, the stored bit is loaded with the inverse of `cfg_invert`: 1 when `cfg_invert`=0 and 0 when `cfg_invert`=1.
- R2: The clear term is the OR of two parts. The first is (`gclr` XOR `gclr_inv`) AND `cfg_gclr_en`. The second is `pt3` AND `cfg_pt3_rst`. While the clear term is high, the next stored bit is 0. Clear beats preset and beats any clock event.
- R3: The preset term is `pt5` AND `cfg_pt5_ctl` AND `cfg_pt5_set`. While it is high and the clear term is low, the next stored bit is 1, whatever the value of `cfg_invert`.
- R4: With `cfg_store` = 0 or 3 (D type), the stored bit takes the data value on each rising edge of the chosen clock level while the clock enable is high. It holds otherwise.
- R5: With `cfg_store` = 1 (toggle type), the stored bit inverts on an enabled rising clock edge if the data value is 1. It holds otherwise.
- R6: With `cfg_store` = 2 (latch), the stored bit follows the data value while the clock level and the enable are both high. It holds otherwise.
- R7: Global clock i is XORed with `gclk_inv[i]`. `cfg_clk_sel` values 0, 1 and 2 pick global clock 0, 1 or 2. Value 3 picks no clock, so no edge ever occurs.
- R8: If `cfg_pt4_ctl`=1 and `cfg_pt4_clk`=1, the clock level is `pt4` and the enable is held at 1. If `cfg_pt4_ctl`=1 and `cfg_pt4_clk`=0, the enable is `pt4` and the clock comes from R7. If `cfg_pt4_ctl`=0, the enable is 1.
- R9: The data value is `fast_in` when `cfg_d_fast`=1. Otherwise it is `xor_res` XOR `cfg_invert`. The fast path is never inverted.
- R10: `mc_out` is the stored bit when `cfg_out_reg`=1, and the polarity-adjusted combinational value otherwise. `mc_fb` follows the same choice under `cfg_fb_reg`.
- R11: `cfg_oe_sel` values 0..NOE-1 pick `goe[i]`, and value NOE gives 0. Value NOE+1 gives a shared option: `pt5` when PT5 is claimed as an output enable (`cfg_pt5_ctl`=1, `cfg_pt5_set`=0), and 1 otherwise. Higher values give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous power-up reset, active high |
| gclk | input | NCLK | Global clock levels |
| gclk_inv | input | NCLK | Per-clock inversion |
| cfg_clk_sel | input | CSW | Global clock choice |
| gclr | input | 1 | Global clear |
| gclr_inv | input | 1 | Global clear inversion |
| cfg_gclr_en | input | 1 | Global clear enable |
| pt3 | input | 1 | Control term for clear |
| cfg_pt3_rst | input | 1 | PT3 used as clear |
| pt4 | input | 1 | Control term for clock or enable |
| cfg_pt4_ctl | input | 1 | PT4 claimed for control |
| cfg_pt4_clk | input | 1 | PT4 drives clock (1) or enable (0) |
| pt5 | input | 1 | Control term for preset or output enable |
| cfg_pt5_ctl | input | 1 | PT5 claimed for control |
| cfg_pt5_set | input | 1 | PT5 acts as preset (1) or output enable (0) |
| goe | input | NOE | Global output enables |
| cfg_oe_sel | input | OESW | Output-enable choice |
| xor_res | input | 1 | Combinational XOR result |
| fast_in | input | 1 | Fast pin data path |
| cfg_invert | input | 1 | Polarity bit |
| cfg_store | input | 2 | Storage kind |
| cfg_d_fast | input | 1 | Data from fast path |
| cfg_fb_reg | input | 1 | Feedback from stored bit |
| cfg_out_reg | input | 1 | Output from stored bit |
| mc_out | output | 1 | Cell output value |
| mc_fb | output | 1 | Feedback value |
| pad_oe | output | 1 | Pad output enable |

## Verification
Some properties are checked on every cycle. A clear forces 0 on the next cycle, even when a preset is active at the same time. A lone preset forces 1. Power-up loads the inverse of the polarity bit. The stored bit stays put when no clear, preset or enabled clock event is present. The GND choice of the output-enable select keeps the pad disabled.

Other behaviour can only be shown by the bench's scenarios and by a long pseudo-random sweep checked against an arithmetic model. This covers which clock level is chosen and how it is inverted, how PT4 is routed, toggle and latch behaviour, the fast-path bypass of polarity, and the shared output-enable option.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    ST_D    = 2'd0,
    ST_T    = 2'd1,
    ST_LAT  = 2'd2,
    ST_D2   = 2'd3
  } store_t;
endpackage

// File: rtl/mc_clock_route.sv
module mc_clock_route #(
  parameter int NCLK = 3,
  localparam int CSW = $clog2(NCLK + 1)
) (
  input  logic            clk,
  input  logic [NCLK-1:0] gclk,
  input  logic [NCLK-1:0] gclk_inv,
  input  logic [CSW-1:0]  clk_sel,
  input  logic            pt4,
  input  logic            pt4_ctl,
  input  logic            pt4_clk,
  output logic            lvl,
  output logic            rise,
  output logic            ce
);
  logic [NCLK-1:0] geff;
  logic            glvl;
  logic            lvl_q;

  // per-clock optional inversion
  for (genvar i = 0; i < NCLK; i++) begin : g_inv
    assign geff[i] = gclk[i] ^ gclk_inv[i];
  end

  always_comb begin
    glvl = 1'b0;
    for (int i = 0; i < NCLK; i++)
      if (clk_sel == CSW'(i)) glvl = geff[i];
  end

  assign lvl  = (pt4_ctl && pt4_clk) ? pt4 : glvl;
  assign ce   = (pt4_ctl && !pt4_clk) ? pt4 : 1'b1;

  // history tracks level even during reset, so release makes no false edge
  always_ff @(posedge clk) lvl_q <= lvl;

  assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/mc_async_ctl.sv
module mc_async_ctl #(
  parameter int NOE = 4,
  localparam int OESW = $clog2(NOE + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gclr,
  input  logic            gclr_inv,
  input  logic            gclr_en,
  input  logic            pt3,
  input  logic            pt3_rst,
  input  logic            pt5,
  input  logic            pt5_ctl,
  input  logic            pt5_set,
  input  logic [NOE-1:0]  goe,
  input  logic [OESW-1:0] oe_sel,
  output logic            clr,
  output logic            pre,
  output logic            pad_oe
);
  logic shared_oe;

  assign clr = ((gclr ^ gclr_inv) & gclr_en) | (pt3 & pt3_rst);
  assign pre = pt5 & pt5_ctl & pt5_set;

  // constant 1 unless PT5 is claimed as an output enable
  assign shared_oe = (pt5_ctl && !pt5_set) ? pt5 : 1'b1;

  always_comb begin
    pad_oe = 1'b0;
    for (int i = 0; i < NOE; i++)
      if (oe_sel == OESW'(i)) pad_oe = goe[i];
    if (oe_sel == OESW'(NOE + 1)) pad_oe = shared_oe;
  end

  assert_gnd_oe_R11: assert property (@(posedge clk) disable iff (rst)
    (oe_sel == OESW'(NOE)) |-> !pad_oe);
endmodule

// File: rtl/mc_storage.sv
module mc_storage
  import mc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  store_t mode,
  input  logic   init_val,
  input  logic   d,
  input  logic   lvl,
  input  logic   rise,
  input  logic   ce,
  input  logic   clr,
  input  logic   pre,
  output logic   q
);
  logic cap;

  assign cap = (mode == ST_LAT) ? (lvl & ce) : (rise & ce);

  always_ff @(posedge clk) begin
    if (rst)      q <= init_val;
    else if (clr) q <= 1'b0;
    else if (pre) q <= 1'b1;
    else if (cap) begin
      case (mode)
        ST_T:    q <= q ^ d;
        default: q <= d;
      endcase
    end
  end

  assert_powerup_R1: assert property (@(posedge clk)
    rst |=> (q == $past(init_val)));
  assert_clear_wins_R2: assert property (@(posedge clk) disable iff (rst)
    clr |=> !q);
  assert_preset_R3: assert property (@(posedge clk) disable iff (rst)
    (pre && !clr) |=> q);
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!clr && !pre && !cap) |=> $stable(q));
endmodule

// File: rtl/mc_cell.sv
module mc_cell #(
  parameter int NCLK = 3,
  parameter int NOE  = 4,
  localparam int CSW  = $clog2(NCLK + 1),
  localparam int OESW = $clog2(NOE + 2)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCLK-1:0] gclk,
  input  logic [NCLK-1:0] gclk_inv,
  input  logic [CSW-1:0]  cfg_clk_sel,
  input  logic            gclr,
  input  logic            gclr_inv,
  input  logic            cfg_gclr_en,
  input  logic            pt3,
  input  logic            cfg_pt3_rst,
  input  logic            pt4,
  input  logic            cfg_pt4_ctl,
  input  logic            cfg_pt4_clk,
  input  logic            pt5,
  input  logic            cfg_pt5_ctl,
  input  logic            cfg_pt5_set,
  input  logic [NOE-1:0]  goe,
  input  logic [OESW-1:0] cfg_oe_sel,
  input  logic            xor_res,
  input  logic            fast_in,
  input  logic            cfg_invert,
  input  logic [1:0]      cfg_store,
  input  logic            cfg_d_fast,
  input  logic            cfg_fb_reg,
  input  logic            cfg_out_reg,
  output logic            mc_out,
  output logic            mc_fb,
  output logic            pad_oe
);
  import mc_pkg::*;

  logic lvl, rise, ce, clr, pre, q, comb_v, d_v;

  assign comb_v = xor_res ^ cfg_invert;
  assign d_v    = cfg_d_fast ? fast_in : comb_v;

  mc_clock_route #(.NCLK(NCLK)) u_clk (
    .clk(clk), .gclk(gclk), .gclk_inv(gclk_inv), .clk_sel(cfg_clk_sel),
    .pt4(pt4), .pt4_ctl(cfg_pt4_ctl), .pt4_clk(cfg_pt4_clk),
    .lvl(lvl), .rise(rise), .ce(ce));

  mc_async_ctl #(.NOE(NOE)) u_ctl (
    .clk(clk), .rst(rst), .gclr(gclr), .gclr_inv(gclr_inv),
    .gclr_en(cfg_gclr_en), .pt3(pt3), .pt3_rst(cfg_pt3_rst),
    .pt5(pt5), .pt5_ctl(cfg_pt5_ctl), .pt5_set(cfg_pt5_set),
    .goe(goe), .oe_sel(cfg_oe_sel), .clr(clr), .pre(pre), .pad_oe(pad_oe));

  mc_storage u_st (
    .clk(clk), .rst(rst), .mode(store_t'(cfg_store)), .init_val(~cfg_invert),
    .d(d_v), .lvl(lvl), .rise(rise), .ce(ce), .clr(clr), .pre(pre), .q(q));

  assign mc_out = cfg_out_reg ? q : comb_v;
  assign mc_fb  = cfg_fb_reg  ? q : comb_v;
endmodule

// File: tb/mc_cell_test.sv
module mc_cell_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst;
  logic [2:0] gclk, gclk_inv;
  logic [1:0] cfg_clk_sel, cfg_store;
  logic gclr, gclr_inv, cfg_gclr_en, pt3, cfg_pt3_rst, pt4, cfg_pt4_ctl, cfg_pt4_clk;
  logic pt5, cfg_pt5_ctl, cfg_pt5_set;
  logic [3:0] goe;
  logic [2:0] cfg_oe_sel;
  logic xor_res, fast_in, cfg_invert, cfg_d_fast, cfg_fb_reg, cfg_out_reg;
  logic mc_out, mc_fb, pad_oe;

  mc_cell uut (.*);

  int total = 0, bad = 0;
  logic m_q, m_plvl;
  logic [31:0] seed = 32'h1234_abcd;

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  function automatic logic model_lvl();
    logic [2:0] ge = gclk ^ gclk_inv;
    logic g = (cfg_clk_sel < 2'd3) ? ge[cfg_clk_sel] : 1'b0;
    return (cfg_pt4_ctl && cfg_pt4_clk) ? pt4 : g;
  endfunction

  function automatic logic model_oe();
    if (cfg_oe_sel < 3'd4) return goe[cfg_oe_sel];
    if (cfg_oe_sel == 3'd5) return (cfg_pt5_ctl && !cfg_pt5_set) ? pt5 : 1'b1;
    return 1'b0;
  endfunction

  // one system cycle; the bench model advances alongside
  task automatic tick();
    logic l, ce, r, d, c, p, nq;
    l  = model_lvl();
    ce = (cfg_pt4_ctl && !cfg_pt4_clk) ? pt4 : 1'b1;
    r  = l && !m_plvl;
    d  = cfg_d_fast ? fast_in : (xor_res ^ cfg_invert);
    c  = ((gclr ^ gclr_inv) && cfg_gclr_en) || (pt3 && cfg_pt3_rst);
    p  = pt5 && cfg_pt5_ctl && cfg_pt5_set;
    nq = m_q;
    if (rst) nq = !cfg_invert;
    else if (c) nq = 1'b0;
    else if (p) nq = 1'b1;
    else if (cfg_store == 2'd2) begin if (l && ce) nq = d; end
    else if (cfg_store == 2'd1) begin if (r && ce && d) nq = !m_q; end
    else if (r && ce) nq = d;
    @(posedge clk); #2;
    m_q = nq; m_plvl = l;
  endtask

  task automatic pulse2();
    gclk[2] = 1'b0; tick(); gclk[2] = 1'b1; tick();
  endtask

  initial begin
    #(8 * 190000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_q = 1'b0; m_plvl = 1'b0;
    rst = 1; gclk = 0; gclk_inv = 0; cfg_clk_sel = 0; cfg_store = 0;
    gclr = 0; gclr_inv = 0; cfg_gclr_en = 0; pt3 = 0; cfg_pt3_rst = 0;
    pt4 = 0; cfg_pt4_ctl = 0; cfg_pt4_clk = 0; pt5 = 0; cfg_pt5_ctl = 0; cfg_pt5_set = 0;
    goe = 0; cfg_oe_sel = 3'd4; xor_res = 0; fast_in = 0; cfg_invert = 0;
    cfg_d_fast = 0; cfg_fb_reg = 1; cfg_out_reg = 1;
    tick(); chk(mc_out, 1'b1, "R1 init inv0");
    cfg_invert = 1; tick(); chk(mc_out, 1'b0, "R1 init inv1");
    chk(pad_oe, 1'b0, "R11 gnd");
    rst = 0;
    // R4 D capture on gclk0
    tick(); chk(mc_out, 1'b0, "R4 no edge");
    gclk[0] = 1; tick(); chk(mc_out, 1'b1, "R4 capture");
    xor_res = 1; tick(); chk(mc_out, 1'b1, "R4 hold high level");
    gclk[0] = 0; tick(); gclk[0] = 1; tick(); chk(mc_out, 1'b0, "R4 capture 0");
    // R7 no-clock encoding and inversion
    cfg_clk_sel = 3; xor_res = 0; gclk = 0; tick(); gclk = 3'b111; tick();
    chk(mc_out, 1'b0, "R7 sel3 none");
    cfg_clk_sel = 1; gclk_inv = 3'b010; tick(); chk(mc_out, 1'b0, "R7 inv low");
    gclk[1] = 0; tick(); chk(mc_out, 1'b1, "R7 inverted edge");
    cfg_clk_sel = 2; gclk_inv = 0; xor_res = 1; tick(); chk(mc_out, 1'b1, "R7 sel2 level");
    pulse2(); chk(mc_out, 1'b0, "R7 sel2 edge");
    // R3 / R2
    cfg_pt5_ctl = 1; cfg_pt5_set = 1; pt5 = 1; tick(); chk(mc_out, 1'b1, "R3 preset");
    cfg_gclr_en = 1; gclr = 1; tick(); chk(mc_out, 1'b0, "R2 clear over preset");
    gclr = 0; tick(); chk(mc_out, 1'b1, "R3 preset again");
    gclr_inv = 1; tick(); chk(mc_out, 1'b0, "R2 inverted clear");
    gclr_inv = 0; tick(); cfg_gclr_en = 0; cfg_pt3_rst = 1; pt3 = 1; tick();
    chk(mc_out, 1'b0, "R2 pt3 clear");
    pt3 = 0; cfg_pt3_rst = 0; pt5 = 0; cfg_pt5_ctl = 0; cfg_pt5_set = 0; tick();
    // R5 toggle
    cfg_store = 1; xor_res = 0; pulse2(); chk(mc_out, 1'b1, "R5 toggle up");
    pulse2(); chk(mc_out, 1'b0, "R5 toggle down");
    xor_res = 1; pulse2(); chk(mc_out, 1'b0, "R5 no toggle");
    // R6 latch
    cfg_store = 2; tick(); xor_res = 0; tick(); chk(mc_out, 1'b1, "R6 transparent");
    gclk[2] = 0; tick(); xor_res = 1; tick(); chk(mc_out, 1'b1, "R6 hold");
    gclk[2] = 1; tick(); chk(mc_out, 1'b0, "R6 reopen");
    // R8 PT4 routing
    cfg_store = 0; cfg_pt4_ctl = 1; cfg_pt4_clk = 1; pt4 = 0; xor_res = 0; tick();
    pulse2(); chk(mc_out, 1'b0, "R8 gclk ignored");
    pt4 = 1; tick(); chk(mc_out, 1'b1, "R8 pt4 clock");
    cfg_pt4_clk = 0; pt4 = 0; xor_res = 1; pulse2(); chk(mc_out, 1'b1, "R8 ce low");
    pt4 = 1; pulse2(); chk(mc_out, 1'b0, "R8 ce high");
    cfg_pt4_ctl = 0;
    // R9 fast path
    cfg_d_fast = 1; fast_in = 1; pulse2(); chk(mc_out, 1'b1, "R9 fast not inverted");
    fast_in = 0; pulse2(); chk(mc_out, 1'b0, "R9 fast 0");
    cfg_d_fast = 0;
    // R10 output and feedback selection
    cfg_out_reg = 0; cfg_invert = 0; xor_res = 1; #1;
    chk(mc_out, 1'b1, "R10 comb out"); chk(mc_fb, 1'b0, "R10 reg fb");
    cfg_invert = 1; #1; chk(mc_out, 1'b0, "R10 comb polarity");
    cfg_fb_reg = 0; xor_res = 0; #1; chk(mc_fb, 1'b1, "R10 comb fb");
    // R11 output enable select
    goe = 4'b0101;
    for (int s = 0; s < 8; s++) begin
      cfg_oe_sel = 3'(s);
      for (int k = 0; k < 4; k++) begin
        cfg_pt5_ctl = k[1]; cfg_pt5_set = k[0]; pt5 = 1'b0; #1;
        chk(pad_oe, model_oe(), "R11 sel");
        pt5 = 1'b1; #1;
        chk(pad_oe, model_oe(), "R11 sel");
      end
    end
    cfg_pt5_ctl = 0; pt5 = 0;
    // pseudo-random sweep against the bench model
    rst = 1; tick(); tick(); rst = 0;
    for (int n = 0; n < 4000; n++) begin
      seed = nxt(seed);
      {gclk, gclr, pt3, pt4, pt5, goe, xor_res, fast_in} = seed[13:0];
      rst = (seed[31:26] == 6'd0);
      if (n % 32 == 0) begin
        logic [31:0] c = nxt(seed ^ 32'h5a5a_0f0f);
        {gclk_inv, cfg_clk_sel, gclr_inv, cfg_gclr_en, cfg_pt3_rst, cfg_pt4_ctl,
         cfg_pt4_clk, cfg_pt5_ctl, cfg_pt5_set, cfg_oe_sel, cfg_invert, cfg_store,
         cfg_d_fast, cfg_fb_reg, cfg_out_reg} = c[21:0];
        cfg_gclr_en = cfg_gclr_en & c[25] & c[26];
        cfg_pt3_rst = cfg_pt3_rst & c[27];
        cfg_fb_reg = 1'b1;
      end
      tick();
      chk(mc_fb, m_q, (cfg_store == 2'd1) ? "R5 sweep" :
                      (cfg_store == 2'd2) ? "R6 sweep" : "R4 sweep");
      chk(mc_out, cfg_out_reg ? m_q : (xor_res ^ cfg_invert), "R10 sweep");
      chk(pad_oe, model_oe(), "R11 sweep");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule